// File: doc/BRIEF.md
# Host I/O Register Decoder

This block sits between a 16-bit-address host I/O bus and a small bank of on-board registers. The upper twelve address bits are compared against a relocatable base address to form a board enable. The base address is assigned by a configuration step outside this block and arrives as a plain input, together with a flag that says the assignment is valid. The low four address bits then pick one of sixteen registers. The active-low host read and write strobes qualify that choice and turn it into a one-hot select, a one-cycle read pulse at the start of a read, and a one-cycle write pulse once the write strobe is released.

The block also steers the bidirectional host data bus. It enables its outward driver only while the host reads this board, and it returns the read data supplied by the register bank. While the host writes, it enables the inward path and captures the host data. All outputs are registered on the local clock, so each one reflects the bus state sampled at the previous rising edge.

Top module: `hostio_reg_decoder`

## Requirements
- R1: `board_en` is high one clock after an edge at which the registered configured flag is high and `addr[15:4]` equals the registered base address; otherwise it is low.
- R2: `reg_sel` is one-hot with bit `addr[3:0]` set when a valid read or write of this board was sampled at the last edge, and all zero otherwise.
- R3: `reg_rd` carries bit `addr[3:0]` for exactly one cycle, on the first edge of a valid read (IOR low, IOW high, board enabled). It stays zero while the read continues.
- R4: `dout_en` is high, and `dout` equals `rd_data`, only after an edge that sampled a valid read of this board; `dout` is zero otherwise. `din_en` is high only after an edge that sampled a valid write. The two enables are never high together.
- R5: While `board_en` is low, `reg_sel`, `reg_rd`, `dout_en` and `din_en` are all zero.
- R6: IOR and IOW low together count as no access: no select, no enable, and any write in progress is dropped without a write pulse.
- R7: A write pulse `reg_wr` with bit k appears on the edge that first sees IOW high after a valid write. k and `wr_data` are the address bits [3:0] and `host_din` from the last edge at which IOW was low. The pulse requires the configured flag to still be set.
- R8: `base_addr` is captured only at edges where `configured` is high. Changes while it is low are ignored, and a board that is not configured never asserts `board_en`.
- R9: After reset every output is zero and the board is unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| configured | input | 1 | Base address assignment is valid |
| base_addr | input | 12 | Assigned base for address bits 15..4 |
| addr | input | 16 | Host I/O address |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| host_din | input | 16 | Data arriving from the host bus |
| rd_data | input | 16 | Read data from the selected register |
| board_en | output | 1 | Address falls in this board's window |
| reg_sel | output | 16 | One-hot register select during an access |
| reg_rd | output | 16 | One-cycle read pulse per register |
| reg_wr | output | 16 | One-cycle write pulse per register |
| wr_data | output | 16 | Captured write data |
| dout | output | 16 | Data toward the host bus |
| dout_en | output | 1 | Drive the host data bus outward |
| din_en | output | 1 | Pass host data inward |

## Verification
The hardest case is a write that is started and then undone before IOW rises. The undoing can come from IOR falling onto it, from the address leaving the window, or from the configured flag dropping, and the register select must not pulse afterwards. The stimulus includes directed sequences for each of these endings. A long random walk then holds strobes for random lengths and keeps most addresses inside the window, so that overlaps and mid-write address changes happen often. A behavioural model compares all outputs on every clock.

// File: rtl/hostio_dec_pkg.sv
package hostio_dec_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CLASH = 2'd3
    } acc_kind_e;

    // Classify the sampled host strobes for an addressed board.
    function automatic acc_kind_e classify(input logic hit, input logic ior_n, input logic iow_n);
        acc_kind_e k;
        if (!hit) begin
            k = ACC_IDLE;
        end else begin
            case ({ior_n, iow_n})
                2'b01:   k = ACC_READ;
                2'b10:   k = ACC_WRITE;
                2'b00:   k = ACC_CLASH;
                default: k = ACC_IDLE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/hostio_base_match.sv
module hostio_base_match #(
    parameter int BASE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              configured,
    input  logic [BASE_W-1:0] base_addr,
    input  logic [BASE_W-1:0] addr_hi,
    output logic              cfg_ok,
    output logic              hit
);

    typedef struct packed {
        logic              cfg;
        logic [BASE_W-1:0] base;
    } match_st_t;

    match_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cfg = configured;
        if (configured) begin
            st_d.base = base_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_ok = st_q.cfg;
    assign hit    = st_q.cfg && (addr_hi == st_q.base);

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(configured) |-> $stable(st_q.base)); // R8

    AST_UNCFG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(configured) |-> !hit); // R8

endmodule

// File: rtl/hostio_access.sv
module hostio_access
    import hostio_dec_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 16,
    localparam int NREG  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              cfg_ok,
    input  logic [SEL_W-1:0]  addr_lo,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [DATA_W-1:0] host_din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              board_en,
    output logic [NREG-1:0]   reg_sel,
    output logic [NREG-1:0]   reg_rd,
    output logic [NREG-1:0]   reg_wr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              din_en
);

    typedef struct packed {
        logic              board_en;
        logic              rd_act;
        logic              wr_act;
        logic [SEL_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
        logic [NREG-1:0]   sel;
        logic [NREG-1:0]   rd;
        logic [NREG-1:0]   wr;
        logic [DATA_W-1:0] dout;
    } acc_st_t;

    acc_st_t   st_d, st_q;
    acc_kind_e kind;
    logic [NREG-1:0] cur_dec;
    logic [NREG-1:0] wr_dec;

    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign cur_dec[i] = (addr_lo == SEL_W'(i));
        assign wr_dec[i]  = (st_q.wr_idx == SEL_W'(i));
    end

    always_comb begin
        logic rd_now;
        logic wr_now;
        kind   = classify(hit, ior_n, iow_n);
        rd_now = (kind == ACC_READ);
        wr_now = (kind == ACC_WRITE);

        st_d          = st_q;
        st_d.board_en = hit;
        st_d.rd_act   = rd_now;
        st_d.wr_act   = wr_now;
        st_d.sel      = (rd_now || wr_now) ? cur_dec : '0;
        st_d.rd       = (rd_now && !st_q.rd_act) ? cur_dec : '0;
        st_d.wr       = (st_q.wr_act && iow_n && cfg_ok) ? wr_dec : '0;
        st_d.dout     = rd_now ? rd_data : '0;
        if (wr_now) begin
            st_d.wr_idx  = addr_lo;
            st_d.wr_data = host_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign board_en = st_q.board_en;
    assign reg_sel  = st_q.sel;
    assign reg_rd   = st_q.rd;
    assign reg_wr   = st_q.wr;
    assign wr_data  = st_q.wr_data;
    assign dout     = st_q.dout;
    assign dout_en  = st_q.rd_act;
    assign din_en   = st_q.wr_act;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel)); // R2

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd != '0) |=> (reg_rd == '0)); // R3

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_en && din_en)); // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !board_en |-> (reg_sel == '0 && reg_rd == '0 && !dout_en && !din_en)); // R5

    AST_CLASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ior_n && !iow_n) |-> (!dout_en && !din_en && reg_sel == '0)); // R6

    AST_WR_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr != '0) |-> ($past(din_en) && $onehot(reg_wr))); // R7

endmodule

// File: rtl/hostio_reg_decoder.sv
module hostio_reg_decoder #(
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 16,
    localparam int BASE_W = ADDR_W - SEL_W,
    localparam int NREG   = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              configured,
    input  logic [BASE_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [DATA_W-1:0] host_din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              board_en,
    output logic [NREG-1:0]   reg_sel,
    output logic [NREG-1:0]   reg_rd,
    output logic [NREG-1:0]   reg_wr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              din_en
);

    logic cfg_ok;
    logic hit;

    hostio_base_match #(
        .BASE_W (BASE_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .configured (configured),
        .base_addr  (base_addr),
        .addr_hi    (addr[ADDR_W-1:SEL_W]),
        .cfg_ok     (cfg_ok),
        .hit        (hit)
    );

    hostio_access #(
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .cfg_ok   (cfg_ok),
        .addr_lo  (addr[SEL_W-1:0]),
        .ior_n    (ior_n),
        .iow_n    (iow_n),
        .host_din (host_din),
        .rd_data  (rd_data),
        .board_en (board_en),
        .reg_sel  (reg_sel),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .wr_data  (wr_data),
        .dout     (dout),
        .dout_en  (dout_en),
        .din_en   (din_en)
    );

endmodule

// File: tb/test_hostio_reg_decoder.sv
module test_hostio_reg_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        configured = 1'b0;
    logic [11:0] base_addr = '0;
    logic [15:0] addr = '0;
    logic        ior_n = 1'b1;
    logic        iow_n = 1'b1;
    logic [15:0] host_din = '0;
    logic [15:0] rd_data = '0;
    logic        board_en;
    logic [15:0] reg_sel, reg_rd, reg_wr, wr_data, dout;
    logic        dout_en, din_en;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    hostio_reg_decoder i_hostio_reg_decoder (
        .clk(clk), .rst_n(rst_n), .configured(configured), .base_addr(base_addr),
        .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .host_din(host_din), .rd_data(rd_data),
        .board_en(board_en), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .wr_data(wr_data), .dout(dout), .dout_en(dout_en), .din_en(din_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, compared every clock
    bit        m_cfg, m_rda, m_wra;
    int        m_base, m_widx, m_wdat;
    always @(posedge clk) begin
        int  e_sel, e_rd, e_wr, e_dout, lo;
        bit  hit, rda, wra, e_en;
        if (!rst_n) begin
            m_cfg = 0; m_rda = 0; m_wra = 0; m_base = 0; m_widx = 0; m_wdat = 0;
        end else begin
            lo    = int'(addr[3:0]);
            hit   = m_cfg && (int'(addr[15:4]) == m_base);
            rda   = hit && !ior_n && iow_n;
            wra   = hit && !iow_n && ior_n;
            e_en  = hit;
            e_sel = (rda || wra) ? (1 << lo) : 0;
            e_rd  = (rda && !m_rda) ? (1 << lo) : 0;
            e_wr  = (m_wra && iow_n && m_cfg) ? (1 << m_widx) : 0;
            e_dout = rda ? int'(rd_data) : 0;
            if (wra) begin
                m_widx = lo;
                m_wdat = int'(host_din);
            end
            m_rda = rda;
            m_wra = wra;
            m_cfg = configured;
            if (configured) m_base = int'(base_addr);
            #2;
            chk("R1 board_en", 32'(board_en), 32'(e_en));
            chk("R2 reg_sel", 32'(reg_sel), e_sel);
            chk("R3 reg_rd", 32'(reg_rd), e_rd);
            chk("R7 reg_wr", 32'(reg_wr), e_wr);
            chk("R7 wr_data", 32'(wr_data), m_wdat);
            chk("R4 dout", 32'(dout), e_dout);
            chk("R4 dout_en", 32'(dout_en), 32'(rda));
            chk("R4 din_en", 32'(din_en), 32'(wra));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sample just after the model compare of the edge that ends this call
    task automatic after_edge();
        @(posedge clk);
        #3;
    endtask

    initial begin
        step(3);
        // R9: reset state
        chk("R9 board_en", 32'(board_en), 0);
        chk("R9 reg_sel", 32'(reg_sel), 0);
        chk("R9 wr_data", 32'(wr_data), 0);
        chk("R9 dout_en/din_en", 32'({dout_en, din_en}), 0);
        rst_n = 1'b1;

        // R8: base changes while unconfigured are ignored
        base_addr = 12'h2A3; addr = 16'h2A35; ior_n = 1'b0;
        step(3);
        chk("R8 unconfigured silent", 32'({board_en, dout_en}), 0);
        ior_n = 1'b1;
        configured = 1'b1; step(1);
        configured = 1'b0; base_addr = 12'h111; step(2);
        configured = 1'b1; base_addr = 12'h2A3; step(2);

        // R3/R4: read of register 5
        rd_data = 16'hBEEF; addr = 16'h2A35; ior_n = 1'b0;
        after_edge();
        chk("R3 read pulse reg5", 32'(reg_rd), 32'h20);
        chk("R4 dout on read", 32'(dout), 32'hBEEF);
        after_edge();
        chk("R3 pulse single", 32'(reg_rd), 0);
        step(1); ior_n = 1'b1; step(1);

        // R5: read outside the window
        addr = 16'h2B35; ior_n = 1'b0;
        after_edge();
        chk("R5 off-window quiet", 32'({board_en, reg_sel, dout_en}), 0);
        step(1); ior_n = 1'b1; step(1);

        // R7: write register 9, data from last low cycle
        addr = 16'h2A39; iow_n = 1'b0; host_din = 16'h1111; step(1);
        host_din = 16'h2222; step(1);
        iow_n = 1'b1; host_din = 16'h9999;
        after_edge();
        chk("R7 write pulse reg9", 32'(reg_wr), 32'h200);
        chk("R7 write data", 32'(wr_data), 32'h2222);
        step(1);

        // R6: IOR falls onto a write -> dropped
        addr = 16'h2A33; iow_n = 1'b0; host_din = 16'h3333; step(1);
        ior_n = 1'b0;
        after_edge();
        chk("R6 clash no enable", 32'({dout_en, din_en, reg_sel}), 0);
        step(1); iow_n = 1'b1; ior_n = 1'b1;
        after_edge();
        chk("R6 aborted write no pulse", 32'(reg_wr), 0);
        step(1);

        // R1: address leaves window mid-write -> no pulse
        addr = 16'h2A34; iow_n = 1'b0; step(1);
        addr = 16'h0034; step(1);
        iow_n = 1'b1;
        after_edge();
        chk("R1 left window no pulse", 32'(reg_wr), 0);
        step(1);

        // R8: configuration dropped mid-write -> no pulse
        addr = 16'h2A36; iow_n = 1'b0; step(1);
        configured = 1'b0; step(1);
        iow_n = 1'b1; step(2);
        chk("R8 deconfigured silent", 32'({board_en, reg_wr}), 0);
        configured = 1'b1; step(2);

        // Random walk, compared every clock by the model
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) configured = ~configured;
            if (r >= 2 && r < 4) base_addr = 12'($urandom_range(0, 4095));
            if ($urandom_range(0, 3) == 0)
                addr = ($urandom_range(0, 3) != 0) ? {base_addr, 4'($urandom_range(0, 15))}
                                                    : 16'($urandom_range(0, 65535));
            if ($urandom_range(0, 2) == 0) ior_n = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 2) == 0) iow_n = ($urandom_range(0, 2) != 0);
            host_din = 16'($urandom_range(0, 65535));
            rd_data  = 16'($urandom_range(0, 65535));
            step(1);
        end
        ior_n = 1'b1; iow_n = 1'b1;
        step(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule